// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the host-facing front end of a bank of configuration registers, reached through two byte-wide I/O addresses. One address acts as an index port and the other as a data port. Access stays closed after reset. The host opens it by writing a two-byte key to the index port, and closes it again with a one-byte lock command. While access is open, an index-port write selects a register, and data-port reads and writes reach that register.

One index is held inside the block. It stores the logical device number, and every other register access carries that number downstream, so each device has its own bank of registers. Defined device numbers are 2, 3, 0xB and 0xC for serial ports, 4 for a switch device, 5 for a keyboard controller, 7 for a port-80 capture, 0xD for the bus bridge and 0xE for a mailbox. The block does not check the device number against this list.

Host cycles arrive as decoded single-cycle read/write strobes with an address and a data byte. Forwarded accesses go out in the same cycle as the host strobe, on a downstream register interface. Read data from that interface is returned to the host in the same cycle.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the port is closed, the stored index and the stored device number are both 0, there is no downstream request, and reads of either port return 0xFF.
- R2: Two consecutive index-port (address 0x2E) writes of 0xA5 open the port. Index-port writes are the only accesses that count toward this sequence.
- R3: While closed, non-key index writes do not change the stored index, data-port (address 0x2F) writes raise no downstream request, and reads of either port return 0xFF.
- R4: A non-key byte written to the index port after the first 0xA5 restarts the sequence. A single 0xA5 after it leaves the port closed.
- R5: Writing 0xAA to the index port while open closes the port. The 0xAA byte is not stored as the index.
- R6: While open, an index-port write of any byte other than 0xAA stores that byte as the index, and an index-port read returns it.
- R7: While open with index 0x07, a data write stores the logical device number inside the block and a data read returns it. Neither access raises a downstream request.
- R8: While open with an index other than 0x07, a data write raises the request in the same cycle with the write flag at 1. The request carries the device number, the index and the data byte.
- R9: While open with an index other than 0x07, a data read raises the request with the write flag at 0, and the host read data equals the downstream read data in the same cycle.
- R10: The device number is kept across lock and unlock, and it returns to 0 on reset.
- R11: Accesses to addresses other than 0x2E and 0x2F raise no request, change no state, and read as 0xFF.
- R12: A cycle with both read and write strobes asserted is handled as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWr | input | 1 | Host write strobe, one cycle |
| ioRd | input | 1 | Host read strobe, one cycle |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWdata | input | DATA_W | Host write byte |
| ioRdata | output | DATA_W | Host read byte, valid in the strobe cycle |
| cfgReq | output | 1 | Downstream register access |
| cfgWrite | output | 1 | Downstream write flag |
| cfgDev | output | DATA_W | Selected logical device number |
| cfgIdx | output | DATA_W | Register index |
| cfgWdata | output | DATA_W | Downstream write byte |
| cfgRdata | input | DATA_W | Downstream read byte, same cycle |

## Verification
If the lock state is wrong, the error appears at the ports in the very next strobe cycle. A port that is closed when it should be open reads 0xFF and raises no request, while a port that is open when it should be closed forwards accesses it should drop. A wrong stored index or device number first appears on cfgIdx or cfgDev of the next forwarded access, or in an index-port read. For that reason the scenarios read back the index and the device number after every change of lock state, and after every ignored write.

// File: rtl/cfg_index_pkg.sv
package cfg_index_pkg;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_HALF   = 2'd1,
    LK_OPEN   = 2'd2
  } lockState_t;

  typedef struct packed {
    logic idxLoad;
    logic devLoad;
    logic fwdReq;
    logic fwdWrite;
    logic idxRead;
    logic dataRead;
  } ctrlStrobe_t;

endpackage

// File: rtl/cfg_index_ctrl.sv
module cfg_index_ctrl
  import cfg_index_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h2E,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h2F,
  parameter logic [DATA_W-1:0] KEY_BYTE   = 'hA5,
  parameter logic [DATA_W-1:0] LOCK_BYTE  = 'hAA,
  parameter logic [DATA_W-1:0] DEV_INDEX  = 'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] curIdx,
  output ctrlStrobe_t       strobe,
  output lockState_t        lockState
);

  lockState_t stateQ, stateD;
  logic hitIdx, hitData, wrAcc, rdAcc, isOpen, devSlot;

  assign hitIdx  = (ioAddr == INDEX_PORT);
  assign hitData = (ioAddr == DATA_PORT);
  assign wrAcc   = ioWr;
  assign rdAcc   = ioRd & ~ioWr;
  assign isOpen  = (stateQ == LK_OPEN);
  assign devSlot = (curIdx == DEV_INDEX);

  always_comb begin
    stateD = stateQ;
    if (wrAcc && hitIdx) begin
      unique case (stateQ)
        LK_CLOSED: if (ioWdata == KEY_BYTE) stateD = LK_HALF;
        LK_HALF:   stateD = (ioWdata == KEY_BYTE) ? LK_OPEN : LK_CLOSED;
        LK_OPEN:   if (ioWdata == LOCK_BYTE) stateD = LK_CLOSED;
        default:   stateD = LK_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= LK_CLOSED;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.idxLoad  = isOpen & wrAcc & hitIdx & (ioWdata != LOCK_BYTE);
    strobe.devLoad  = isOpen & wrAcc & hitData & devSlot;
    strobe.fwdReq   = isOpen & hitData & (wrAcc | rdAcc) & ~devSlot;
    strobe.fwdWrite = wrAcc;
    strobe.idxRead  = isOpen & rdAcc & hitIdx;
    strobe.dataRead = isOpen & rdAcc & hitData;
  end

  assign lockState = stateQ;

endmodule

// File: rtl/cfg_index_dp.sv
module cfg_index_dp
  import cfg_index_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] DEV_INDEX = 'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] cfgRdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              cfgReq,
  output logic              cfgWrite,
  output logic [DATA_W-1:0] cfgDev,
  output logic [DATA_W-1:0] cfgIdx,
  output logic [DATA_W-1:0] cfgWdata,
  output logic [DATA_W-1:0] idxSel,
  output logic [DATA_W-1:0] devSel
);

  localparam logic [DATA_W-1:0] IDLE_READ = '1;

  logic [DATA_W-1:0] idxQ, devQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      devQ <= '0;
    end else begin
      if (strobe.idxLoad) idxQ <= ioWdata;
      if (strobe.devLoad) devQ <= ioWdata;
    end
  end

  always_comb begin
    ioRdata = IDLE_READ;
    if (strobe.idxRead)
      ioRdata = idxQ;
    else if (strobe.dataRead)
      ioRdata = (idxQ == DEV_INDEX) ? devQ : cfgRdata;
  end

  assign cfgReq   = strobe.fwdReq;
  assign cfgWrite = strobe.fwdReq & strobe.fwdWrite;
  assign cfgDev   = devQ;
  assign cfgIdx   = idxQ;
  assign cfgWdata = (strobe.fwdReq & strobe.fwdWrite) ? ioWdata : '0;
  assign idxSel   = idxQ;
  assign devSel   = devQ;

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_index_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h2E,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h2F,
  parameter logic [DATA_W-1:0] KEY_BYTE   = 'hA5,
  parameter logic [DATA_W-1:0] LOCK_BYTE  = 'hAA,
  parameter logic [DATA_W-1:0] DEV_INDEX  = 'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  output logic              cfgReq,
  output logic              cfgWrite,
  output logic [DATA_W-1:0] cfgDev,
  output logic [DATA_W-1:0] cfgIdx,
  output logic [DATA_W-1:0] cfgWdata,
  input  logic [DATA_W-1:0] cfgRdata
);

  ctrlStrobe_t       strobe;
  lockState_t        lockState;
  logic [DATA_W-1:0] idxSel, devSel;

  cfg_index_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_PORT(INDEX_PORT),
    .DATA_PORT(DATA_PORT), .KEY_BYTE(KEY_BYTE), .LOCK_BYTE(LOCK_BYTE),
    .DEV_INDEX(DEV_INDEX)
  ) ctrl (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .curIdx(idxSel), .strobe(strobe), .lockState(lockState)
  );

  cfg_index_dp #(
    .DATA_W(DATA_W), .DEV_INDEX(DEV_INDEX)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioWdata(ioWdata),
    .cfgRdata(cfgRdata), .ioRdata(ioRdata), .cfgReq(cfgReq),
    .cfgWrite(cfgWrite), .cfgDev(cfgDev), .cfgIdx(cfgIdx),
    .cfgWdata(cfgWdata), .idxSel(idxSel), .devSel(devSel)
  );

endmodule

// File: rtl/cfg_index_chk.sv
module cfg_index_chk
  import cfg_index_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 'h2E,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'h2F,
  parameter logic [DATA_W-1:0] KEY_BYTE   = 'hA5,
  parameter logic [DATA_W-1:0] LOCK_BYTE  = 'hAA,
  parameter logic [DATA_W-1:0] DEV_INDEX  = 'h07
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioWr,
  input logic              ioRd,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioWdata,
  input logic [DATA_W-1:0] ioRdata,
  input logic              cfgReq,
  input logic              cfgWrite,
  input lockState_t        lockState,
  input logic [DATA_W-1:0] idxSel,
  input logic [DATA_W-1:0] devSel
);

  logic idxWr;
  assign idxWr = ioWr && (ioAddr == INDEX_PORT);

  assert_closed_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lockState != LK_OPEN) |-> !cfgReq);

  assert_closed_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((lockState != LK_OPEN) && ioRd && !ioWr && (ioAddr == DATA_PORT)) |-> (ioRdata == '1));

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((lockState == LK_HALF) && idxWr && (ioWdata == KEY_BYTE)) |=> (lockState == LK_OPEN));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((lockState == LK_HALF) && idxWr && (ioWdata != KEY_BYTE)) |=> (lockState == LK_CLOSED));

  assert_lock_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((lockState == LK_OPEN) && idxWr && (ioWdata == LOCK_BYTE)) |=> ((lockState == LK_CLOSED) && $stable(idxSel)));

  assert_dev_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !((lockState == LK_OPEN) && ioWr && (ioAddr == DATA_PORT) && (idxSel == DEV_INDEX)) |=> $stable(devSel));

  assert_dev_no_fwd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (idxSel == DEV_INDEX) |-> !cfgReq);

  assert_both_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReq && ioWr && ioRd) |-> cfgWrite);

endmodule

bind cfg_index_port cfg_index_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_PORT(INDEX_PORT),
  .DATA_PORT(DATA_PORT), .KEY_BYTE(KEY_BYTE), .LOCK_BYTE(LOCK_BYTE),
  .DEV_INDEX(DEV_INDEX)
) chkInst (
  .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
  .ioWdata(ioWdata), .ioRdata(ioRdata), .cfgReq(cfgReq), .cfgWrite(cfgWrite),
  .lockState(lockState), .idxSel(idxSel), .devSel(devSel)
);

// File: tb/cfg_index_port_test.sv
`timescale 1ns/1ps
module cfg_index_port_test;

  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0] ioWdata = '0;
  logic [7:0] ioRdata, cfgDev, cfgIdx, cfgWdata, cfgRdata;
  logic cfgReq, cfgWrite;

  int checks = 0;
  int fails = 0;
  logic capReq, capWrite;
  logic [7:0] capDev, capIdx, capWdata, capRdata;

  always #4 clk = ~clk;

  // downstream model: read data derived from the index
  assign cfgRdata = cfgIdx ^ 8'hC3;

  cfg_index_port uut (
    .clk(clk), .rstN(rstN), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .cfgReq(cfgReq), .cfgWrite(cfgWrite),
    .cfgDev(cfgDev), .cfgIdx(cfgIdx), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWr = wr; ioRd = rd; ioAddr = a; ioWdata = d;
    #1;
    capReq = cfgReq; capWrite = cfgWrite; capDev = cfgDev;
    capIdx = cfgIdx; capWdata = cfgWdata; capRdata = ioRdata;
    @(posedge clk);
    #1;
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic openPort();
    bus(1, 0, IDX, 8'hA5);
    bus(1, 0, IDX, 8'hA5);
  endtask

  task automatic testReset();
    applyReset();
    bus(0, 1, DAT, 8'h00);
    check("R1 data read after reset", capRdata, 8'hFF);
    check("R1 no request", {7'd0, capReq}, 8'h00);
    bus(0, 1, IDX, 8'h00);
    check("R1 index read after reset", capRdata, 8'hFF);
    check("R1 device after reset", capDev, 8'h00);
  endtask

  task automatic testClosed();
    bus(1, 0, IDX, 8'h10);
    bus(1, 0, DAT, 8'h55);
    check("R3 closed write no request", {7'd0, capReq}, 8'h00);
    bus(0, 1, DAT, 8'h00);
    check("R3 closed data read", capRdata, 8'hFF);
    bus(1, 0, 16'h002D, 8'hA5);
    bus(1, 0, 16'h0080, 8'hA5);
    bus(0, 1, DAT, 8'h00);
    check("R11 keys at other address do not open", capRdata, 8'hFF);
  endtask

  task automatic testRestart();
    bus(1, 0, IDX, 8'hA5);
    bus(1, 0, IDX, 8'h11);
    bus(1, 0, IDX, 8'hA5);
    bus(0, 1, DAT, 8'h00);
    check("R4 broken key stays closed", capRdata, 8'hFF);
    bus(1, 0, IDX, 8'h00);
  endtask

  task automatic testOpen();
    bus(1, 0, IDX, 8'hA5);
    bus(0, 1, DAT, 8'h00);
    bus(1, 0, IDX, 8'hA5);
    bus(0, 1, IDX, 8'h00);
    check("R2 open index read", capRdata, 8'h00);
    check("R3 closed index write ignored", capIdx, 8'h00);
    bus(1, 0, IDX, 8'h20);
    bus(0, 1, IDX, 8'h00);
    check("R6 index readback", capRdata, 8'h20);
    bus(0, 1, DAT, 8'h00);
    check("R9 read request", {6'd0, capReq, capWrite}, 8'h02);
    check("R9 read data", capRdata, 8'h20 ^ 8'hC3);
    check("R9 read index", capIdx, 8'h20);
    bus(0, 1, 16'h0100, 8'h00);
    check("R11 other address read", capRdata, 8'hFF);
    check("R11 other address no request", {7'd0, capReq}, 8'h00);
  endtask

  task automatic testDevice();
    bus(1, 0, IDX, 8'h07);
    bus(1, 0, DAT, 8'h0D);
    check("R7 device write no request", {7'd0, capReq}, 8'h00);
    bus(0, 1, DAT, 8'h00);
    check("R7 device readback", capRdata, 8'h0D);
    check("R7 device read no request", {7'd0, capReq}, 8'h00);
  endtask

  task automatic testForward();
    bus(1, 0, IDX, 8'h30);
    bus(1, 0, DAT, 8'h9A);
    check("R8 write request", {6'd0, capReq, capWrite}, 8'h03);
    check("R8 write device", capDev, 8'h0D);
    check("R8 write index", capIdx, 8'h30);
    check("R8 write data", capWdata, 8'h9A);
    bus(1, 1, DAT, 8'h44);
    check("R12 both strobes is write", {6'd0, capReq, capWrite}, 8'h03);
    check("R12 both strobes data", capWdata, 8'h44);
  endtask

  task automatic testLock();
    bus(1, 0, IDX, 8'hAA);
    bus(0, 1, IDX, 8'h00);
    check("R5 index read after lock", capRdata, 8'hFF);
    bus(1, 0, DAT, 8'h12);
    check("R5 no request after lock", {7'd0, capReq}, 8'h00);
    openPort();
    bus(0, 1, IDX, 8'h00);
    check("R5 lock byte not stored", capRdata, 8'h30);
    bus(1, 0, IDX, 8'h07);
    bus(0, 1, DAT, 8'h00);
    check("R10 device kept across lock", capRdata, 8'h0D);
  endtask

  task automatic testResetDevice();
    applyReset();
    openPort();
    bus(1, 0, IDX, 8'h07);
    bus(0, 1, DAT, 8'h00);
    check("R10 device cleared by reset", capRdata, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testClosed();
    testRestart();
    testOpen();
    testDevice();
    testForward();
    testLock();
    testResetDevice();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule